// File: doc/BRIEF.md
# Delayed Read Attempt Limiter

This block drives the far-bus half of a bridged delayed read. When a new request is loaded, it starts a read attempt on the far bus. Each clock in which the target shows both device-select and target-ready counts as a data phase. On every such clock the returned DWORD is written straight into the read data queue that faces the opposite interface. The block accepts one DWORD per clock and never inserts wait states.

An attempt that the target stops before any data has moved is a failed attempt. The block counts failed attempts against a limit held in a register that software can write. While the limit has not been reached, the block waits one idle clock and then issues the read again. When the last allowed attempt fails, the block abandons the request and latches a sticky system-error status. The external error output follows that status only while the error enable bit is set. Once any data has moved, a stop from the target finishes the request, and the block makes no further attempts for it.

The controller is a three-state machine:
- **IDLE**: no request is active.
- **ISSUE**: an attempt is on the bus.
- **GAP**: the one idle clock between a failed attempt and the next one.

Its transitions are:
- *load*: IDLE to ISSUE.
- *finish*: ISSUE to IDLE, after data has moved.
- *give-up*: ISSUE to IDLE, when the limit is exhausted.
- *retry*: ISSUE to GAP, on a failed attempt while attempts remain.
- *resume*: GAP to ISSUE, always after one clock.

Top module: `dread_retry_ctl`

## Requirements
- R1: After reset the block is in IDLE: `rd_active`, `q_push`, `fin_ok`, `fin_fail`, `serr_sts` and `serr_o` are all 0. The attempt limit register holds `LIM_RST` (default 3).
- R2: A `req_load` pulse while the block is idle raises `rd_active` on the next clock. `rd_active` stays high until the attempt terminates.
- R3: While `rd_active` is high, every clock with `tgt_devsel` and `tgt_trdy` both 1 drives `q_push` to 1 in that same clock, with `q_data` equal to `tgt_data`. This holds on consecutive clocks with no gaps.
- R4: A `tgt_stop` in an attempt that has moved no data, when the limit is not yet reached, drops `rd_active` for exactly one clock. A new attempt then starts.
- R5: A `tgt_stop` after at least one data phase of the request, including a data phase in the same clock, pulses `fin_ok` in that clock. `rd_active` is then 0 from the next clock until the next load.
- R6: Let N be the effective limit. The Nth consecutive failed attempt of a request pulses `fin_fail` in the clock of the stop and returns the block to IDLE.
- R7: `cfg_we` writes `cfg_lim` into the attempt limit register at the clock edge. A stored value of 0 behaves as a limit of 1.
- R8: The failed-attempt count clears when a request is loaded and on every data phase, so each new request gets the full limit.
- R9: `serr_sts` is set on the clock after `fin_fail` and stays set until `err_clr`; if both happen together, the set wins. `serr_o` equals `serr_sts` AND `serr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_load | input | 1 | New delayed read request (accepted in IDLE) |
| cfg_we | input | 1 | Write strobe for the attempt limit register |
| cfg_lim | input | CW | Attempt limit value to write |
| serr_en | input | 1 | System-error output enable bit |
| err_clr | input | 1 | Software clear of the sticky error status |
| tgt_devsel | input | 1 | Target has claimed the access |
| tgt_trdy | input | 1 | Target has read data ready |
| tgt_stop | input | 1 | Target terminates the current attempt |
| tgt_data | input | DW | Read data from the target |
| rd_active | output | 1 | Read attempt in progress on the far bus |
| q_push | output | 1 | Write strobe into the opposite-direction read queue |
| q_data | output | DW | DWORD written into the queue |
| fin_ok | output | 1 | Request completed with data (one-clock pulse) |
| fin_fail | output | 1 | Request abandoned at the attempt limit (one-clock pulse) |
| serr_sts | output | 1 | Sticky system-error status |
| serr_o | output | 1 | Gated system-error output |

## Verification
A wrong state register shows within one clock as a mismatch on `rd_active`. A wrong idle gap or a missing gap appears the clock after the stop. A failed-attempt count that is off by one stays hidden until the final attempt of a request, where `fin_fail` arrives one attempt early or late. For that reason, exhaustion is exercised at limits of 0, 1, 3 and 5, and after partial-data and fresh requests. A faulty sticky or gating path shows on `serr_sts` or `serr_o` on the clock after the `fin_fail` or the clear.

// File: rtl/dread_pkg.sv
package dread_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } dr_state_t;
endpackage

// File: rtl/dread_attempt_ctr.sv
module dread_attempt_ctr #(
    parameter int CW      = 4,
    parameter int LIM_RST = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic          lim_we,
    input  logic [CW-1:0] lim_in,
    output logic          exhaust
);
    localparam logic [CW-1:0] LIM_INIT = CW'(LIM_RST);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic [CW:0]   eff_lim;
    logic [CW:0]   cnt_plus;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= LIM_INIT;
        end else if (lim_we) begin
            lim_q <= lim_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        eff_lim  = (lim_q == '0) ? (CW+1)'(1) : {1'b0, lim_q};
        cnt_plus = {1'b0, cnt_q} + 1'b1;
        exhaust  = (cnt_plus >= eff_lim);
    end

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R6
    no_inc_past_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !exhaust);
endmodule

// File: rtl/dread_serr.sv
module dread_serr (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic sts,
    output logic serr_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (set) begin
            sts <= 1'b1;
        end else if (clr) begin
            sts <= 1'b0;
        end
    end

    assign serr_o = sts & en;

    // R9
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !clr) |=> sts);

    // R9
    sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> sts);
endmodule

// File: rtl/dread_retry_ctl.sv
module dread_retry_ctl
    import dread_pkg::*;
#(
    parameter int CW      = 4,
    parameter int DW      = 32,
    parameter int LIM_RST = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_load,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_lim,
    input  logic          serr_en,
    input  logic          err_clr,
    input  logic          tgt_devsel,
    input  logic          tgt_trdy,
    input  logic          tgt_stop,
    input  logic [DW-1:0] tgt_data,
    output logic          rd_active,
    output logic          q_push,
    output logic [DW-1:0] q_data,
    output logic          fin_ok,
    output logic          fin_fail,
    output logic          serr_sts,
    output logic          serr_o
);
    dr_state_t state_q, state_d;
    logic      got_q;
    logic      beat, ended, give_up, retry, exhaust, start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            got_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                got_q <= 1'b0;
            end else if (beat) begin
                got_q <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_active = (state_q == ST_ISSUE);
        start     = (state_q == ST_IDLE) && req_load;
        beat      = rd_active && tgt_devsel && tgt_trdy;
        ended     = rd_active && tgt_stop;
        fin_ok    = ended && (got_q || beat);
        give_up   = ended && !(got_q || beat) && exhaust;
        retry     = ended && !(got_q || beat) && !exhaust;
        fin_fail  = give_up;
        q_push    = beat;
        q_data    = tgt_data;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_load) state_d = ST_ISSUE;
            ST_ISSUE: begin
                if (fin_ok || give_up) state_d = ST_IDLE;
                else if (retry)        state_d = ST_GAP;
            end
            ST_GAP:   state_d = ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    dread_attempt_ctr #(.CW(CW), .LIM_RST(LIM_RST)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start || beat),
        .inc     (retry),
        .lim_we  (cfg_we),
        .lim_in  (cfg_lim),
        .exhaust (exhaust)
    );

    dread_serr u_serr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (give_up),
        .clr    (err_clr),
        .en     (serr_en),
        .sts    (serr_sts),
        .serr_o (serr_o)
    );

    // R3
    push_in_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> rd_active);

    // R4
    gap_after_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> (!rd_active ##1 rd_active));

    // R5
    done_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> !rd_active);

    // R6
    fail_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_fail |=> (serr_sts && !rd_active));

    // R9
    gated_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> serr_sts);

    // R5
    one_ending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_ok && fin_fail));
endmodule

// File: tb/dread_retry_ctl_bench.sv
module dread_retry_ctl_bench;
    localparam int CW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_load, cfg_we, serr_en, err_clr;
    logic [CW-1:0] cfg_lim;
    logic          tgt_devsel, tgt_trdy, tgt_stop;
    logic [DW-1:0] tgt_data;
    logic          rd_active, q_push, fin_ok, fin_fail, serr_sts, serr_o;
    logic [DW-1:0] q_data;

    int checks = 0;
    int fails  = 0;

    int m_mode  = 0;
    int m_att   = 0;
    int m_lim   = 3;
    bit m_got   = 0;
    bit m_serr  = 0;

    always #2 clk = ~clk;

    dread_retry_ctl #(.CW(CW), .DW(DW), .LIM_RST(3)) u_dread_retry_ctl (
        .clk(clk), .rst_n(rst_n), .req_load(req_load), .cfg_we(cfg_we),
        .cfg_lim(cfg_lim), .serr_en(serr_en), .err_clr(err_clr),
        .tgt_devsel(tgt_devsel), .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop),
        .tgt_data(tgt_data), .rd_active(rd_active), .q_push(q_push),
        .q_data(q_data), .fin_ok(fin_ok), .fin_fail(fin_fail),
        .serr_sts(serr_sts), .serr_o(serr_o)
    );

    task automatic cmp(input string tag, input logic act, input logic exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit ld, input bit dv, input bit tr, input bit st,
                        input logic [DW-1:0] d);
        bit e_act, e_push, e_ok, e_fail;
        int effl;
        req_load = ld; tgt_devsel = dv; tgt_trdy = tr; tgt_stop = st; tgt_data = d;
        #1;
        effl   = (m_lim == 0) ? 1 : m_lim;
        e_act  = (m_mode == 1);
        e_push = e_act && dv && tr;
        e_ok   = e_act && st && (m_got || e_push);
        e_fail = e_act && st && !m_got && !e_push && (m_att + 1 >= effl);
        checks++;
        cmp("R2/R4 rd_active", rd_active, e_act);
        cmp("R3 q_push", q_push, e_push);
        if (e_push && q_data !== d) begin
            fails++;
            $display("FAIL R3 q_data actual=%h expected=%h", q_data, d);
        end
        cmp("R5 fin_ok", fin_ok, e_ok);
        cmp("R6 fin_fail", fin_fail, e_fail);
        cmp("R9 serr_sts", serr_sts, m_serr);
        cmp("R9 serr_o", serr_o, m_serr && serr_en);
        if (cfg_we) m_lim = int'(cfg_lim);
        if (e_fail) m_serr = 1;
        else if (err_clr) m_serr = 0;
        case (m_mode)
            0: if (ld) begin m_mode = 1; m_att = 0; m_got = 0; end
            1: begin
                if (e_push) begin m_got = 1; m_att = 0; end
                if (st) begin
                    if (e_ok || e_fail) m_mode = 0;
                    else begin m_att++; m_mode = 2; end
                end
            end
            default: m_mode = 1;
        endcase
        @(negedge clk);
        cfg_we = 0; err_clr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0);
    endtask

    task automatic retry_once();
        step(0, 0, 0, 1, '0);
        step(0, 0, 0, 0, '0);
    endtask

    task automatic set_lim(input int v);
        cfg_we = 1; cfg_lim = CW'(v);
        step(0, 0, 0, 0, '0);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; req_load = 0; cfg_we = 0; cfg_lim = '0; serr_en = 1; err_clr = 0;
        tgt_devsel = 0; tgt_trdy = 0; tgt_stop = 0; tgt_data = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1 reset state
        idle(2);
        // R2 R3 R5 burst with stop on last beat
        step(1, 0, 0, 0, '0);
        step(0, 1, 0, 0, '0);
        step(0, 1, 1, 0, 32'h1111_0001);
        step(0, 1, 1, 0, 32'h1111_0002);
        step(0, 1, 1, 1, 32'h1111_0003);
        idle(2);
        // R4 R8 two retries then data, later stop with no data that clock
        step(1, 0, 0, 0, '0);
        retry_once(); retry_once();
        step(0, 1, 1, 0, 32'hA5A5_0000);
        step(0, 0, 0, 0, '0);
        step(0, 0, 0, 1, '0);
        idle(2);
        // R6 R9 exhaustion at default limit 3, enable on
        step(1, 0, 0, 0, '0);
        retry_once(); retry_once();
        step(0, 0, 0, 1, '0);
        idle(3);
        // R9 clear, then gated output with enable off
        err_clr = 1; step(0, 0, 0, 0, '0);
        idle(1);
        serr_en = 0;
        // R7 limit 1: first failed attempt gives up
        set_lim(1);
        step(1, 0, 0, 0, '0);
        step(0, 0, 0, 1, '0);
        idle(2);
        // R7 limit 0 acts as 1, with clear coinciding with fail (R9 set wins)
        set_lim(0);
        serr_en = 1;
        step(1, 0, 0, 0, '0);
        err_clr = 1; step(0, 0, 0, 1, '0);
        idle(2);
        // R7 R8 limit 5: four retries then data, fresh request gets full limit
        set_lim(5);
        err_clr = 1; step(0, 0, 0, 0, '0);
        step(1, 0, 0, 0, '0);
        for (int i = 0; i < 4; i++) retry_once();
        step(0, 1, 1, 1, 32'h5555_AAAA);
        idle(1);
        step(1, 0, 0, 0, '0);
        for (int i = 0; i < 4; i++) retry_once();
        step(0, 0, 0, 1, '0);
        idle(2);
        // mixed random traffic against the model
        set_lim(2);
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 17) == 0) begin cfg_we = 1; cfg_lim = CW'($urandom); end
            if (($urandom % 23) == 0) err_clr = 1;
            serr_en = $urandom_range(0, 1);
            step(($urandom % 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
                 ($urandom % 4) == 0, $urandom);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule